// File: doc/BRIEF.md
# Windowed Local-Maximum Search Memory

This block is an on-chip memory for a two-dimensional array of 32-bit values, with a search function built in. Apart from ordinary single-word writes and reads, it accepts a search request that names a center cell. It returns the largest value found in the 3x3 neighbourhood of that cell, together with the absolute row and column where that value sits. Search results are registered one clock after the request is accepted.

Storage is split across three row banks, and array row r is kept in bank r mod 3. Any window therefore takes exactly one row from each bank. Each bank reads three adjacent words of its row in one access and picks the largest of them with a three-input comparator. A final three-input comparator picks among the bank winners, after their outputs have been put back into row order. Values are compared as unsigned numbers. When values tie, the upper row wins, and within a row the left column wins.

Window cells that fall outside the array are never candidates. A center cell outside the array produces a result with an out-of-range flag set.

The search port is valid/ready on both sides:
- A request is taken on a clock edge where `srch_valid` and `srch_ready` are both high.
- The result stays in its output register until it is taken on an edge where `res_valid` and `res_ready` are both high.
- `srch_ready` is high only when the result register is empty or is being drained in the same cycle. A stalled consumer therefore holds back new requests without losing any result.

Writes and plain reads use plain enables and are always accepted.

Top module: `winmax_search_mem`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at (`wr_row`, `wr_col`). A read with `rd_en` high presents that word on `rd_data` after the next clock edge. Writes to an address outside the array are ignored, and reads of such an address return 0.
- R2: An accepted search request sets `res_valid` high after the next clock edge, so the result comes one cycle after the request.
- R3: `res_data` equals the unsigned maximum over all in-array cells of the 3x3 window centered on the requested cell.
- R4: `res_row` and `res_col` give the absolute location of the reported maximum, which always lies inside the window.
- R5: Among equal maximum values, the smallest row wins, and then the smallest column within that row.
- R6: At the array edges and corners, window cells outside the array take no part in the comparison.
- R7: A request whose center row is at least ROWS, or whose center column is at least COLS, gives `res_oor`=1, `res_data`=0, `res_row`=0 and `res_col`=0.
- R8: A write on the same clock edge as an accepted search is not visible to that search, which sees the old contents. Later searches see the new data.
- R9: While `res_valid` is high and `res_ready` is low, `srch_ready` is low, and `res_data`, `res_row`, `res_col` and `res_oor` hold steady. After the result is taken with no new request, `res_valid` returns to 0.
- R10: Comparison is unsigned, so 32'hFFFFFFFF beats 32'h7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_row | input | RW | Write row |
| wr_col | input | CW | Write column |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Plain read enable |
| rd_row | input | RW | Read row |
| rd_col | input | CW | Read column |
| rd_data | output | DW | Read data, one cycle after `rd_en` |
| srch_valid | input | 1 | Search request valid |
| srch_ready | output | 1 | Search request can be taken |
| srch_row | input | RW | Window center row |
| srch_col | input | CW | Window center column |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DW | Window maximum value |
| res_row | output | RW | Row of the maximum |
| res_col | output | CW | Column of the maximum |
| res_oor | output | 1 | Center coordinate was out of range |

## Verification
Each search result comes directly from a single access to storage, with no internal pipeline. A wrong bank mapping, a misordered slot or a bad edge mask therefore shows up in the result of the very next search whose window touches the affected cells, one cycle after that request. A wrong row remap shows up as a location that is shifted by a row or that points at the wrong bank's row. A broken tie rule shows up only when equal values share a window, so dedicated windows with deliberate ties are searched. A fault in the output register shows up on the port as a lost or changed result while the consumer stalls.

// File: rtl/winmax_pkg.sv
package winmax_pkg;
  // Position of a bank's row inside the window: above, center, below.
  typedef enum logic [1:0] {
    SLOT_ABOVE  = 2'd0,
    SLOT_CENTER = 2'd1,
    SLOT_BELOW  = 2'd2
  } win_slot_e;

  localparam int unsigned NUM_BANKS = 3;
  localparam int unsigned WIN_W     = 3;
endpackage

// File: rtl/winmax_cmp3.sv
// Three-input unsigned maximum with per-input valid. Strict compare keeps
// the lowest index on ties.
module winmax_cmp3 #(
  parameter int DW = 32
) (
  input  logic [2:0][DW-1:0] cand_val,
  input  logic [2:0]         cand_ok,
  output logic [DW-1:0]      win_val,
  output logic [1:0]         win_idx,
  output logic               win_ok
);
  always_comb begin
    win_val = cand_val[0];
    win_idx = 2'd0;
    win_ok  = cand_ok[0];
    for (int i = 1; i < 3; i++) begin
      if (cand_ok[i] && (!win_ok || cand_val[i] > win_val)) begin
        win_val = cand_val[i];
        win_idx = 2'(i);
        win_ok  = 1'b1;
      end
    end
    if (!win_ok) win_val = '0;
  end
endmodule

// File: rtl/winmax_bank.sv
// One row bank: storage, a three-word row read around a center column,
// and a three-input comparator over those words.
module winmax_bank #(
  parameter int DW    = 32,
  parameter int COLS  = 12,
  parameter int BROWS = 4,
  parameter int LRW   = 2,
  parameter int CW    = 4
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [LRW-1:0] wr_lrow,
  input  logic [CW-1:0]  wr_col,
  input  logic [DW-1:0]  wr_data,
  input  logic [LRW-1:0] s_lrow,
  input  logic           s_row_ok,
  input  logic [CW-1:0]  s_col,
  input  logic [LRW-1:0] rd_lrow,
  input  logic [CW-1:0]  rd_col,
  output logic [DW-1:0]  rd_word,
  output logic [DW-1:0]  b_val,
  output logic [1:0]     b_cidx,
  output logic           b_ok
);
  logic [DW-1:0] mem [BROWS][COLS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_lrow][wr_col] <= wr_data;
  end

  assign rd_word = mem[rd_lrow][rd_col];

  logic [2:0][DW-1:0] tri_val;
  logic [2:0]         tri_ok;

  for (genvar j = 0; j < 3; j++) begin : g_tap
    logic [CW-1:0] cidx;
    logic          cok;
    if (j == 0) begin : g_left
      assign cok  = s_row_ok && (s_col != '0);
      assign cidx = s_col - CW'(1);
    end else if (j == 1) begin : g_mid
      assign cok  = s_row_ok;
      assign cidx = s_col;
    end else begin : g_right
      assign cok  = s_row_ok && (int'(s_col) < COLS - 1);
      assign cidx = s_col + CW'(1);
    end
    assign tri_ok[j]  = cok;
    assign tri_val[j] = cok ? mem[s_lrow][cidx] : '0;
  end

  winmax_cmp3 #(.DW(DW)) u_cmp (
    .cand_val (tri_val),
    .cand_ok  (tri_ok),
    .win_val  (b_val),
    .win_idx  (b_cidx),
    .win_ok   (b_ok)
  );
endmodule

// File: rtl/winmax_search_mem.sv
module winmax_search_mem
  import winmax_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int COLS = 12,
  parameter int DW   = 32,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int BROWS = (ROWS + 2) / 3,
  localparam int LRW   = (BROWS > 1) ? $clog2(BROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_row,
  input  logic [CW-1:0] wr_col,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [DW-1:0] rd_data,
  input  logic          srch_valid,
  output logic          srch_ready,
  input  logic [RW-1:0] srch_row,
  input  logic [CW-1:0] srch_col,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic [RW-1:0] res_row,
  output logic [CW-1:0] res_col,
  output logic          res_oor
);
  // Address decode: bank = row mod 3, local row = row / 3.
  logic [1:0]     wr_bank, rd_bank, ctr_m3;
  logic [LRW-1:0] wr_lrow, rd_lrow;
  logic           wr_in, rd_in, center_ok;

  assign wr_in     = (int'(wr_row) < ROWS) && (int'(wr_col) < COLS);
  assign rd_in     = (int'(rd_row) < ROWS) && (int'(rd_col) < COLS);
  assign center_ok = (int'(srch_row) < ROWS) && (int'(srch_col) < COLS);
  assign wr_bank   = 2'(int'(wr_row) % 3);
  assign rd_bank   = 2'(int'(rd_row) % 3);
  assign ctr_m3    = 2'(int'(srch_row) % 3);
  assign wr_lrow   = LRW'(int'(wr_row) / 3);
  assign rd_lrow   = LRW'(int'(rd_row) / 3);

  logic [NUM_BANKS-1:0][DW-1:0] bk_rd, bk_val;
  logic [NUM_BANKS-1:0][1:0]    bk_cidx;
  logic [NUM_BANKS-1:0]         bk_ok;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic [LRW-1:0] s_lrow;
    logic           s_row_ok;

    // Which window slot this bank serves for the current center row.
    always_comb begin
      int slot;
      int q;
      slot     = (k + 4 - int'(ctr_m3)) % 3;
      q        = int'(srch_row) + slot - 1;
      s_row_ok = center_ok && (q >= 0) && (q < ROWS);
      s_lrow   = (q >= 0) ? LRW'(q / 3) : '0;
    end

    winmax_bank #(
      .DW(DW), .COLS(COLS), .BROWS(BROWS), .LRW(LRW), .CW(CW)
    ) u_bank (
      .clk      (clk),
      .wr_en    (wr_en && wr_in && (wr_bank == 2'(k))),
      .wr_lrow  (wr_lrow),
      .wr_col   (wr_col),
      .wr_data  (wr_data),
      .s_lrow   (s_lrow),
      .s_row_ok (s_row_ok),
      .s_col    (srch_col),
      .rd_lrow  (rd_lrow),
      .rd_col   (rd_col),
      .rd_word  (bk_rd[k]),
      .b_val    (bk_val[k]),
      .b_cidx   (bk_cidx[k]),
      .b_ok     (bk_ok[k])
    );
  end

  // Put bank winners back in row order (above, center, below).
  logic [WIN_W-1:0][DW-1:0] sl_val;
  logic [WIN_W-1:0][1:0]    sl_cidx;
  logic [WIN_W-1:0]         sl_ok;

  always_comb begin
    for (int s = 0; s < WIN_W; s++) begin
      logic [1:0] b;
      b          = 2'((int'(ctr_m3) + s + 2) % 3);
      sl_val[s]  = bk_val[b];
      sl_cidx[s] = bk_cidx[b];
      sl_ok[s]   = bk_ok[b];
    end
  end

  logic [DW-1:0] fin_val;
  logic [1:0]    fin_slot;
  logic          fin_ok;

  winmax_cmp3 #(.DW(DW)) u_final (
    .cand_val (sl_val),
    .cand_ok  (sl_ok),
    .win_val  (fin_val),
    .win_idx  (fin_slot),
    .win_ok   (fin_ok)
  );

  logic [RW-1:0] loc_row;
  logic [CW-1:0] loc_col;
  assign loc_row = RW'(int'(srch_row) + int'(fin_slot) - 1);
  assign loc_col = CW'(int'(srch_col) + int'(sl_cidx[fin_slot]) - 1);

  // Result register with valid/ready.
  logic accept;
  assign srch_ready = !res_valid || res_ready;
  assign accept     = srch_valid && srch_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_row   <= '0;
      res_col   <= '0;
      res_oor   <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_oor   <= !center_ok;
      res_data  <= (center_ok && fin_ok) ? fin_val : '0;
      res_row   <= (center_ok && fin_ok) ? loc_row : '0;
      res_col   <= (center_ok && fin_ok) ? loc_col : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_in ? bk_rd[rd_bank] : '0;
  end
endmodule

// File: rtl/winmax_search_mem_chk.sv
module winmax_search_mem_chk #(
  parameter int ROWS = 10,
  parameter int COLS = 12,
  parameter int DW   = 32,
  parameter int RW   = 4,
  parameter int CW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srch_valid,
  input logic          srch_ready,
  input logic [RW-1:0] srch_row,
  input logic [CW-1:0] srch_col,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic [RW-1:0] res_row,
  input logic [CW-1:0] res_col,
  input logic          res_oor
);
  logic acc, ctr_in;
  assign acc    = srch_valid && srch_ready;
  assign ctr_in = (int'(srch_row) < ROWS) && (int'(srch_col) < COLS);

  a_r2_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) &&
      $stable(res_row) && $stable(res_col) && $stable(res_oor)));

  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !srch_ready);

  a_r7_oor_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ctr_in) |=> (res_oor && res_data == '0));

  a_r4_row_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ctr_in) |=> (!res_oor &&
      int'(res_row) + 1 >= int'($past(srch_row)) &&
      int'(res_row) <= int'($past(srch_row)) + 1 &&
      int'(res_col) + 1 >= int'($past(srch_col)) &&
      int'(res_col) <= int'($past(srch_col)) + 1));
endmodule

bind winmax_search_mem winmax_search_mem_chk #(
  .ROWS(ROWS), .COLS(COLS), .DW(DW), .RW(RW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_ready(srch_ready),
  .srch_row(srch_row), .srch_col(srch_col), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .res_row(res_row),
  .res_col(res_col), .res_oor(res_oor)
);

// File: tb/tb_winmax_search_mem.sv
`timescale 1ns/1ps
module tb_winmax_search_mem;
  localparam int ROWS = 10;
  localparam int COLS = 12;
  localparam int DW   = 32;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, srch_valid = 1'b0, res_ready = 1'b1;
  logic [RW-1:0] wr_row = '0, rd_row = '0, srch_row = '0;
  logic [CW-1:0] wr_col = '0, rd_col = '0, srch_col = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data, res_data;
  logic [RW-1:0] res_row;
  logic [CW-1:0] res_col;
  logic srch_ready, res_valid, res_oor;

  always #2.5 clk = ~clk;

  winmax_search_mem #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data), .srch_valid(srch_valid), .srch_ready(srch_ready),
    .srch_row(srch_row), .srch_col(srch_col), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_row(res_row),
    .res_col(res_col), .res_oor(res_oor)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] model [ROWS][COLS];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference scan: rows top to bottom, columns left to right, strict greater.
  task automatic ref_max(input int r, input int c, output logic [DW-1:0] v,
                         output int vr, output int vc);
    bit any = 0;
    v = '0; vr = 0; vc = 0;
    for (int rr = r - 1; rr <= r + 1; rr++)
      for (int cc = c - 1; cc <= c + 1; cc++)
        if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS)
          if (!any || model[rr][cc] > v) begin
            any = 1; v = model[rr][cc]; vr = rr; vc = cc;
          end
  endtask

  task automatic wr(input int r, input int c, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_row = RW'(r); wr_col = CW'(c); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (r < ROWS && c < COLS) model[r][c] = d;
  endtask

  task automatic rd_check(input string req, input int r, input int c,
                          input logic [DW-1:0] exp);
    @(negedge clk);
    rd_en = 1; rd_row = RW'(r); rd_col = CW'(c);
    @(negedge clk);
    rd_en = 0;
    chk(req, rd_data, exp);
  endtask

  task automatic search(input string req, input int r, input int c);
    logic [DW-1:0] ev; int er, ec;
    ref_max(r, c, ev, er, ec);
    @(negedge clk);
    srch_valid = 1; srch_row = RW'(r); srch_col = CW'(c);
    @(negedge clk);
    srch_valid = 0;
    chk({"R2 valid ", req}, res_valid, 1);
    chk({"R3 value ", req}, res_data, ev);
    chk({"R4 row ", req}, res_row, er);
    chk({"R4 col ", req}, res_col, ec);
  endtask

  task automatic t_reset;
    chk("R9 reset res_valid", res_valid, 0);
    chk("R9 reset srch_ready", srch_ready, 1);
    chk("R1 reset rd_data", rd_data, 0);
  endtask

  task automatic t_fill_read;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        wr(r, c, (32'h9E3779B9 * 32'(r * COLS + c + 1)) ^ 32'(r << 20));
    rd_check("R1 read 0,0", 0, 0, model[0][0]);
    rd_check("R1 read 4,7", 4, 7, model[4][7]);
    rd_check("R1 read last", ROWS - 1, COLS - 1, model[ROWS-1][COLS-1]);
    wr(ROWS, 0, 32'hDEAD_BEEF);
    rd_check("R1 oor read zero", ROWS, 0, 0);
    rd_check("R1 oor write no alias", ROWS - 1, 0, model[ROWS-1][0]);
  endtask

  task automatic t_interior;
    search("R3 interior 4,5", 4, 5);
    search("R3 interior 5,5", 5, 5);
    search("R3 interior 6,2", 6, 2);
    search("R3 interior 2,9", 2, 9);
  endtask

  task automatic t_edges;
    search("R6 corner TL", 0, 0);
    search("R6 corner TR", 0, COLS - 1);
    search("R6 corner BL", ROWS - 1, 0);
    search("R6 corner BR", ROWS - 1, COLS - 1);
    search("R6 top edge", 0, 6);
    // Edge cell holds the largest value, inside neighbours beaten.
    wr(ROWS - 1, COLS - 1, 32'hF000_0001);
    search("R6 bottom right max", ROWS - 2, COLS - 2);
    chk("R6 edge max location", res_row * 100 + res_col, (ROWS-1)*100 + COLS-1);
  endtask

  task automatic t_ties;
    for (int r = 3; r <= 5; r++)
      for (int c = 4; c <= 6; c++) wr(r, c, 32'h0000_0100);
    wr(5, 4, 32'hABCD_0000); wr(4, 6, 32'hABCD_0000); wr(4, 5, 32'hABCD_0000);
    search("R5 tie row", 4, 5);
    chk("R5 tie picks 4,5", res_row * 100 + res_col, 405);
    wr(3, 6, 32'hABCD_0000); wr(3, 5, 32'hABCD_0000);
    search("R5 tie upper row", 4, 5);
    chk("R5 tie picks 3,5", res_row * 100 + res_col, 305);
  endtask

  task automatic t_unsigned;
    for (int r = 6; r <= 8; r++)
      for (int c = 6; c <= 8; c++) wr(r, c, 32'h0000_0010);
    wr(7, 7, 32'h7FFF_FFFF);
    wr(8, 8, 32'hFFFF_FFFF);
    search("R10 unsigned", 7, 7);
    chk("R10 picks all-ones", res_data, 32'hFFFF_FFFF);
  endtask

  task automatic t_oor;
    @(negedge clk);
    srch_valid = 1; srch_row = RW'(ROWS); srch_col = 0;
    @(negedge clk);
    srch_valid = 0;
    chk("R7 row oor flag", res_oor, 1);
    chk("R7 row oor data", res_data, 0);
    chk("R7 row oor loc", res_row * 100 + res_col, 0);
    @(negedge clk);
    srch_valid = 1; srch_row = 2; srch_col = CW'(COLS);
    @(negedge clk);
    srch_valid = 0;
    chk("R7 col oor flag", res_oor, 1);
    search("R7 valid clears flag", 2, 2);
    chk("R7 in-range flag low", res_oor, 0);
  endtask

  task automatic t_collision;
    logic [DW-1:0] ev; int er, ec;
    ref_max(2, 3, ev, er, ec);
    @(negedge clk);
    wr_en = 1; wr_row = 2; wr_col = 3; wr_data = 32'hFFFF_FFF0;
    srch_valid = 1; srch_row = 2; srch_col = 3;
    @(negedge clk);
    wr_en = 0; srch_valid = 0;
    chk("R8 same-cycle old value", res_data, ev);
    chk("R8 same-cycle old loc", res_row * 100 + res_col, er * 100 + ec);
    model[2][3] = 32'hFFFF_FFF0;
    search("R8 later sees new", 2, 3);
    chk("R8 new value", res_data, 32'hFFFF_FFF0);
  endtask

  task automatic t_backpressure;
    logic [DW-1:0] ev; int er, ec;
    ref_max(4, 4, ev, er, ec);
    @(negedge clk);
    res_ready = 0; srch_valid = 1; srch_row = 4; srch_col = 4;
    @(negedge clk);
    chk("R9 held valid", res_valid, 1);
    chk("R9 ready low on stall", srch_ready, 0);
    srch_row = 0; srch_col = 0;
    @(negedge clk);
    chk("R9 data held", res_data, ev);
    chk("R9 loc held", res_row * 100 + res_col, er * 100 + ec);
    srch_valid = 0; res_ready = 1;
    @(negedge clk);
    chk("R9 drained", res_valid, 0);
  endtask

  bit done = 0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fill_read();
    t_interior();
    t_edges();
    t_ties();
    t_unsigned();
    t_oor();
    t_collision();
    t_backpressure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule